// File: doc/BRIEF.md
# Supervisory reset and watchdog generator

This block is the digital core of a processor supervisor. It combines three reset sources: a supply-good flag from an external threshold comparator, an active-low push-button style manual reset, and an internal watchdog. From them it produces one reset for the processor. Whenever any source is active, reset is asserted. Once every source has cleared, reset is held for a fixed number of clock cycles and then released.

The watchdog counts cycles while reset is released. Any change of level on the strobe input, rising or falling, clears it. If the strobe stays quiet for the full watchdog window, a normal-length reset pulse is issued. The watchdog has no enable. It is held at zero while reset is asserted and while the system runs from backup power. A processor that never strobes therefore sees a periodic reset.

The block drives the reset in two forms. The first is an active-low level. The second is a pull-down enable for an active-high open-drain pin: the pin is released (high impedance) while reset is asserted and pulled low otherwise. Both time constants are parameters given in clock cycles.

Top module: `supv_reset_core`

## Requirements
- R1: While the synchronous reset `rst_n` is low, and on the cycle it is released, `rst_n_o` is 0. It stays 0 until exactly RST_CYC rising edges after the release, provided no source is active.
- R2: A 0 on `supply_ok_i` sampled at a clock edge drives `rst_n_o` to 0 after that edge. After `supply_ok_i` returns to 1, `rst_n_o` stays 0 through RST_CYC-1 further edges and becomes 1 after the RST_CYC-th edge.
- R3: A new low sample of `supply_ok_i` while the hold-off is running restarts the hold-off from zero. Release is timed from the last low sample only.
- R4: `man_rst_n_i` passes through a two-flop synchroniser. A low level asserts reset after the third clock edge. Reset stays asserted while the input is low, and `rst_n_o` returns to 1 after RST_CYC+2 edges following the input's return high.
- R5: After release, if `wd_strobe_i` does not change for WD_CYC consecutive edges, `rst_n_o` goes to 0 for exactly RST_CYC cycles.
- R6: Both a rising and a falling change of `wd_strobe_i` clear the watchdog count. Strobing at intervals shorter than WD_CYC keeps `rst_n_o` at 1.
- R7: The watchdog count is held at zero while reset is asserted. After any release it runs a full WD_CYC cycles before it can expire.
- R8: With the strobe held constant, reset pulses repeat with a period of WD_CYC+RST_CYC cycles.
- R9: While `backup_i` is 1 the watchdog is held at zero and never expires. After `backup_i` returns to 0, expiry comes WD_CYC edges later.
- R10: `rst_pulldown_o` is 1 (pin pulled low) exactly when `rst_n_o` is 1, and 0 (pin released) while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok_i | input | 1 | Synchronised flag, 1 when supply is above the reset threshold |
| man_rst_n_i | input | 1 | Asynchronous active-low manual reset request |
| wd_strobe_i | input | 1 | Asynchronous watchdog strobe; any level change is activity |
| backup_i | input | 1 | Synchronised flag, 1 while running from backup power |
| rst_n_o | output | 1 | Active-low reset to the processor |
| rst_pulldown_o | output | 1 | Pull-down enable of the active-high open-drain reset pin |

## Verification
The bench builds the core with a hold-off of 20 cycles and a watchdog window of 50 cycles instead of the large defaults. With these values, repeated stuck-strobe pulses, a manual reset held longer than the watchdog window, and a backup period spanning several windows all fit within a short run. The short constants also let every release and expiry be checked on its exact edge, one cycle either side. This makes an off-by-one in either counter, or in the synchroniser depth, visible at the ports.

// File: rtl/supv_pkg.sv
// Package: shared helpers for the supervisory reset core.
// Assumes counters run from 0 to n-1, so they need clog2(n) bits.
package supv_pkg;

    // Default time constants in clock cycles (200 ms and 1.6 s at 1 MHz)
    localparam int unsigned DEF_RST_CYC = 200_000;
    localparam int unsigned DEF_WD_CYC  = 1_600_000;

    // Bits needed for a counter that spans 0..n-1, at least one
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/supv_sync2.sv
// Module: per-bit two-flop synchroniser for asynchronous level inputs.
// Assumes each bit is an independent level; RST_VAL gives each bit's
// inactive value, loaded by the synchronous reset.
module supv_sync2 #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end

        assign q[i] = sync_q;
    end

endmodule

// File: rtl/supv_rst_timer.sv
// Module: reset hold-off timer.
// Asserts while trig_i is high and for RST_CYC cycles after it falls.
// Any trigger restarts the count from zero. Starts asserted out of reset.
module supv_rst_timer
    import supv_pkg::*;
#(
    parameter int unsigned RST_CYC = DEF_RST_CYC
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trig_i,
    output logic                           active_o,
    output logic [cnt_width(RST_CYC)-1:0]  cnt_o
);

    localparam int unsigned   CW   = cnt_width(RST_CYC);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    logic          act_q;
    logic [CW-1:0] cnt_q;

    // Hold-off state: restart on trigger, count while asserted, release at end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (trig_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q) begin
            if (cnt_q == LAST) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = act_q;
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/supv_wdog.sv
// Module: watchdog timer with level-change detection on the strobe.
// Assumes strobe_i is already synchronised. The count clears on any
// strobe change, while hold_i is high, and on expiry. expire_o is a
// one-cycle request raised when WD_CYC quiet cycles have elapsed.
module supv_wdog
    import supv_pkg::*;
#(
    parameter int unsigned WD_CYC = DEF_WD_CYC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strobe_i,
    input  logic                          hold_i,
    output logic                          expire_o,
    output logic [cnt_width(WD_CYC)-1:0]  cnt_o
);

    localparam int unsigned   CW   = cnt_width(WD_CYC);
    localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

    logic          prev_q;
    logic          activity;
    logic [CW-1:0] cnt_q;

    // Previous strobe sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe_i;
    end

    assign activity = strobe_i ^ prev_q;
    assign expire_o = !hold_i && !activity && (cnt_q == LAST);

    // Idle-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (hold_i || activity || expire_o) cnt_q <= '0;
        else                                  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/supv_reset_core.sv
// Module: top of the supervisory reset core.
// Merges supply-low, manual reset and watchdog expiry into one reset
// with a fixed hold-off. Drives it active-low and as an open-drain
// pull-down enable. supply_ok_i and backup_i are assumed synchronised;
// man_rst_n_i and wd_strobe_i are synchronised here.
module supv_reset_core
    import supv_pkg::*;
#(
    parameter int unsigned RST_CYC = DEF_RST_CYC,
    parameter int unsigned WD_CYC  = DEF_WD_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic man_rst_n_i,
    input  logic wd_strobe_i,
    input  logic backup_i,
    output logic rst_n_o,
    output logic rst_pulldown_o
);

    localparam int unsigned RW = cnt_width(RST_CYC);
    localparam int unsigned WW = cnt_width(WD_CYC);

    logic [1:0]    sync_q;
    logic          man_sync;
    logic          strobe_sync;
    logic          wd_expire;
    logic          trig;
    logic          rst_act;
    logic [RW-1:0] rst_cnt;
    logic [WW-1:0] wd_cnt;

    // Bit 0: manual reset (idle high); bit 1: strobe (idle low)
    supv_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wd_strobe_i, man_rst_n_i}),
        .q     (sync_q)
    );

    assign man_sync    = sync_q[0];
    assign strobe_sync = sync_q[1];

    // Any active source (re)starts the hold-off
    assign trig = !supply_ok_i || !man_sync || wd_expire;

    supv_rst_timer #(.RST_CYC(RST_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig),
        .active_o (rst_act),
        .cnt_o    (rst_cnt)
    );

    supv_wdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_sync),
        .hold_i   (rst_act || backup_i),
        .expire_o (wd_expire),
        .cnt_o    (wd_cnt)
    );

    assign rst_n_o        = !rst_act;
    assign rst_pulldown_o = !rst_act;

endmodule

// File: rtl/supv_reset_chk.sv
// Module: assertion checker for supv_reset_core, attached by bind.
// Assumes RST_CYC >= 2 and WD_CYC >= 2.
module supv_reset_chk
    import supv_pkg::*;
#(
    parameter int unsigned RST_CYC = DEF_RST_CYC,
    parameter int unsigned WD_CYC  = DEF_WD_CYC
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           supply_ok_i,
    input logic                           backup_i,
    input logic                           rst_n_o,
    input logic                           man_sync,
    input logic [cnt_width(RST_CYC)-1:0]  rst_cnt,
    input logic [cnt_width(WD_CYC)-1:0]   wd_cnt
);

    AST_SUPPLY_LOW_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !rst_n_o); // R2

    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> $past(supply_ok_i)); // R2

    AST_MANUAL_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        !man_sync |=> !rst_n_o); // R4

    AST_WDOG_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_o |=> (wd_cnt == '0)); // R7

    AST_WDOG_HELD_IN_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |=> (wd_cnt == '0)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rst_cnt) < RST_CYC) && (32'(wd_cnt) < WD_CYC)); // R5

endmodule

bind supv_reset_core supv_reset_chk #(.RST_CYC(RST_CYC), .WD_CYC(WD_CYC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .backup_i    (backup_i),
    .rst_n_o     (rst_n_o),
    .man_sync    (man_sync),
    .rst_cnt     (rst_cnt),
    .wd_cnt      (wd_cnt)
);

// File: tb/supv_reset_core_tb_top.sv
// Directed bench: inputs change and outputs are sampled on falling edges.
module supv_reset_core_tb_top;

    localparam int unsigned RST_T = 20;
    localparam int unsigned WD_T  = 50;

    logic clk = 1'b0;
    logic rst_n;
    logic supply_ok;
    logic man_n;
    logic strobe;
    logic backup;
    logic rst_n_o;
    logic rst_pd;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    supv_reset_core #(.RST_CYC(RST_T), .WD_CYC(WD_T)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok_i    (supply_ok),
        .man_rst_n_i    (man_n),
        .wd_strobe_i    (strobe),
        .backup_i       (backup),
        .rst_n_o        (rst_n_o),
        .rst_pulldown_o (rst_pd)
    );

    // Advance n rising edges, ending on a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare the reset output; the pull-down must always mirror it (R10)
    task automatic chk(input logic exp, input string req, input string what);
        n_run++;
        if (rst_n_o !== exp) begin
            n_fail++;
            $display("FAIL %s %s: rst_n_o=%b expected=%b", req, what, rst_n_o, exp);
        end
        n_run++;
        if (rst_pd !== exp) begin
            n_fail++;
            $display("FAIL R10 %s: rst_pulldown_o=%b expected=%b", what, rst_pd, exp);
        end
    endtask

    // Power-on reset, then check release after RST_T edges (R1)
    task automatic do_por();
        rst_n = 1'b0; supply_ok = 1'b1; man_n = 1'b1; strobe = 1'b0; backup = 1'b0;
        step(3);
        chk(1'b0, "R1", "held in power-on reset");
        rst_n = 1'b1;
        step(RST_T - 1);
        chk(1'b0, "R1", "one edge before release");
        step(1);
        chk(1'b1, "R1", "released after hold-off");
    endtask

    task automatic t_supply();
        do_por();
        supply_ok = 1'b0;
        step(1);
        chk(1'b0, "R2", "supply low asserts");
        step(5);
        supply_ok = 1'b1;
        step(RST_T - 1);
        chk(1'b0, "R2", "still held before hold-off end");
        step(1);
        chk(1'b1, "R2", "released after hold-off");
    endtask

    task automatic t_dip();
        do_por();
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(10);
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        step(RST_T - 1);
        chk(1'b0, "R3", "held, timed from second dip");
        step(1);
        chk(1'b1, "R3", "released after restarted hold-off");
    endtask

    task automatic t_manual();
        do_por();
        man_n = 1'b0;
        step(2);
        chk(1'b1, "R4", "synchroniser delay");
        step(1);
        chk(1'b0, "R4", "manual low asserts");
        step(10);
        chk(1'b0, "R4", "held while input low");
        man_n = 1'b1;
        step(RST_T + 1);
        chk(1'b0, "R4", "held before release");
        step(1);
        chk(1'b1, "R4", "released after hold-off");
    endtask

    task automatic t_wd_held();
        do_por();
        man_n = 1'b0;
        step(3 * WD_T);
        man_n = 1'b1;
        step(RST_T + 2);
        chk(1'b1, "R7", "released after long manual reset");
        step(WD_T - 1);
        chk(1'b1, "R7", "full watchdog window after release");
        step(1);
        chk(1'b0, "R5", "watchdog expiry asserts");
    endtask

    task automatic t_stuck();
        do_por();
        step(WD_T - 1);
        chk(1'b1, "R5", "no expiry before window end");
        step(1);
        chk(1'b0, "R5", "expiry on window end");
        step(RST_T - 1);
        chk(1'b0, "R5", "pulse still held");
        step(1);
        chk(1'b1, "R5", "pulse length equals hold-off");
        step(WD_T - 1);
        chk(1'b1, "R8", "second window running");
        step(1);
        chk(1'b0, "R8", "second pulse at full period");
    endtask

    task automatic t_kick();
        int lows = 0;
        do_por();
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < 30; c++) begin
                step(1);
                if (rst_n_o !== 1'b1) lows++;
            end
            strobe = ~strobe;
        end
        n_run++;
        if (lows != 0) begin
            n_fail++;
            $display("FAIL R6 strobe toggling: low cycles=%0d expected=0", lows);
        end
        step(WD_T - 1);
        chk(1'b1, "R6", "last change cleared count");
    endtask

    task automatic t_backup();
        int lows = 0;
        do_por();
        backup = 1'b1;
        for (int c = 0; c < 3 * WD_T; c++) begin
            step(1);
            if (rst_n_o !== 1'b1) lows++;
        end
        n_run++;
        if (lows != 0) begin
            n_fail++;
            $display("FAIL R9 backup mode: low cycles=%0d expected=0", lows);
        end
        backup = 1'b0;
        step(WD_T - 1);
        chk(1'b1, "R9", "count restarts at backup exit");
        step(1);
        chk(1'b0, "R9", "expiry a full window after backup exit");
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; man_n = 1'b1; strobe = 1'b0; backup = 1'b0;
        @(negedge clk);
        do_por();
        t_supply();
        t_dip();
        t_manual();
        t_wd_held();
        t_stuck();
        t_kick();
        t_backup();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule